// File: doc/BRIEF.md
# Shared Flash Ownership Arbiter

This block decides which master may drive a shared flash device: nobody, an embedded controller, the host, or a configuration loader. Software-visible masters ask for the flash by setting their own request bit in one control/status word. The loader asks through a dedicated pin. The arbiter hands the flash to exactly one owner at a time. It reports that owner in a read-only selection field, and it drives a one-hot select vector toward the pin multiplexer.

A master learns that it owns the flash only by reading the selection field until its own code appears. To release the flash it clears its request and reads until its code is gone. Ownership never moves directly from one master to another. The selection always drops to idle for at least one cycle first, and a new owner is chosen only from idle.

Top module: `flash_owner_arb`

## Requirements
- R1: After reset the selection reads 0 (idle), both request bits read 0, and every bit of `flash_sel_oh` is 0.
- R2: A read at address `CTRL_ADDR` (default 0x1D0) returns the selection code in bits 2:0, the controller request in bit 4 and the host request in bit 5. Every other bit reads 0. A read at any other address returns 0.
- R3: A write at `CTRL_ADDR` loads bit 4 into the controller request and bit 5 into the host request. Data in bits 2:0 has no effect on the selection. A write at any other address changes nothing.
- R4: While the selection is idle, it moves on the next clock edge to the highest-priority active request. The priority order is loader pin (code 4), then controller (code 1), then host (code 2). With no active request it stays idle.
- R5: While the current owner keeps its request asserted, the selection does not change, whatever the other requesters do.
- R6: When the current owner's request is low at a clock edge, the selection becomes idle at that edge.
- R7: Between two different owners the selection reads idle for at least one cycle.
- R8: `flash_sel_oh` equals the selection code. Bit 0 is the controller, bit 1 the host and bit 2 the loader, and at most one bit is ever set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register address |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data (combinational) |
| cfg_req | input | 1 | Configuration loader request pin |
| flash_sel_oh | output | 3 | One-hot flash mux select (controller, host, loader) |

## Verification
Starting from idle, the bench applies all eight combinations of the loader pin and the two request bits. This separates the three levels of priority from each other and from the no-request case. For every resulting owner it then cycles through all eight patterns of the competing requests while the owner keeps its own request set, which separates holding from preemption. Handover sequences clear the owner while another master is waiting. These show the release edge and the mandatory idle cycle. Writes to other addresses and to the read-only bits show that they cannot move the state.

// File: rtl/flash_owner_arb.sv
module flash_owner_arb #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter logic [ADDR_W-1:0] CTRL_ADDR = 12'h1D0,
  parameter int CTRL_REQ_BIT = 4,
  parameter int HOST_REQ_BIT = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  input  logic              cfg_req,
  output logic [2:0]        flash_sel_oh
);
  localparam logic [2:0] SEL_IDLE = 3'd0;
  localparam logic [2:0] SEL_CTRL = 3'd1;
  localparam logic [2:0] SEL_HOST = 3'd2;
  localparam logic [2:0] SEL_CFG  = 3'd4;
  localparam logic [DATA_W-1:0] USED_MASK =
    (DATA_W'(1) << CTRL_REQ_BIT) | (DATA_W'(1) << HOST_REQ_BIT);

  logic [2:0] sel, sel_nxt;
  logic       ctrl_req, host_req;
  logic       hit, owner_active;
  logic [DATA_W-1:0] status;
  logic       unused_wbits;

  assign hit          = (reg_addr == CTRL_ADDR);
  assign unused_wbits = ^(reg_wdata & ~USED_MASK);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_req <= 1'b0;
      host_req <= 1'b0;
    end else if (reg_wr && hit) begin
      ctrl_req <= reg_wdata[CTRL_REQ_BIT];
      host_req <= reg_wdata[HOST_REQ_BIT];
    end
  end

  assign owner_active = |(sel & {cfg_req, host_req, ctrl_req});

  always_comb begin
    sel_nxt = sel;
    if (sel == SEL_IDLE) begin
      if (cfg_req)       sel_nxt = SEL_CFG;
      else if (ctrl_req) sel_nxt = SEL_CTRL;
      else if (host_req) sel_nxt = SEL_HOST;
    end else if (!owner_active) begin
      sel_nxt = SEL_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) sel <= SEL_IDLE;
    else        sel <= sel_nxt;
  end

  always_comb begin
    status = '0;
    status[2:0] = sel;
    status[CTRL_REQ_BIT] = ctrl_req;
    status[HOST_REQ_BIT] = host_req;
  end

  assign reg_rdata    = hit ? status : '0;
  assign flash_sel_oh = sel;

  assert_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(flash_sel_oh));

  assert_cfg_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_IDLE && cfg_req) |=> (sel == SEL_CFG));

  assert_hold_owner_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_IDLE && owner_active) |=> $stable(sel));

  assert_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_IDLE && !owner_active) |=> (sel == SEL_IDLE));

  assert_idle_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel != SEL_IDLE) |=> (sel == SEL_IDLE || $stable(sel)));
endmodule

// File: tb/flash_owner_arb_bench.sv
module flash_owner_arb_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] ADDR = 12'h1D0;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [11:0] reg_addr = ADDR;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        cfg_req = 1'b0;
  logic [2:0]  flash_sel_oh;

  int vectors = 0;
  int errors  = 0;

  flash_owner_arb u_flash_owner_arb (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cfg_req(cfg_req),
    .flash_sel_oh(flash_sel_oh));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  function automatic logic [31:0] word(logic c, logic h);
    return (32'(c) << 4) | (32'(h) << 5);
  endfunction

  function automatic logic [2:0] prio(logic f, logic c, logic h);
    return f ? 3'd4 : c ? 3'd1 : h ? 3'd2 : 3'd0;
  endfunction

  task automatic wr(logic [11:0] a, logic [31:0] d);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    tick();
    reg_wr = 1'b0; reg_addr = ADDR;
  endtask

  task automatic check_sel(string req, logic [2:0] e);
    chk(req, {29'd0, reg_rdata[2:0]}, {29'd0, e});
    chk("R8", {29'd0, flash_sel_oh}, {29'd0, e});
  endtask

  task automatic clear_all();
    cfg_req = 1'b0;
    wr(ADDR, 32'd0);
    tick(); tick();
    check_sel("R6", 3'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); rst_n = 1'b1;
    chk("R1", reg_rdata, 32'd0);
    chk("R1", {29'd0, flash_sel_oh}, 32'd0);
    reg_addr = 12'h1D4;
    chk("R2", reg_rdata, 32'd0);
    reg_addr = ADDR;

    wr(12'h1D4, 32'hFFFF_FFFF); tick();
    chk("R3", reg_rdata, 32'd0);
    wr(ADDR, 32'h0000_0007); tick();
    chk("R3", reg_rdata, 32'd0);

    for (int k = 0; k < 8; k++) begin
      logic c, h, f;
      logic [2:0] own;
      c = k[0]; h = k[1]; f = k[2];
      own = prio(f, c, h);
      wr(ADDR, word(c, h) | 32'h7);
      check_sel("R4", 3'd0);
      cfg_req = f;
      tick();
      check_sel("R4", own);
      chk("R2", reg_rdata, word(c, h) | 32'(own));
      if (own != 3'd0) begin
        for (int j = 0; j < 8; j++) begin
          logic c2, h2, f2;
          c2 = j[0] | (own == 3'd1);
          h2 = j[1] | (own == 3'd2);
          f2 = j[2] | (own == 3'd4);
          cfg_req = f2;
          wr(ADDR, word(c2, h2));
          tick();
          check_sel("R5", own);
        end
      end
      clear_all();
    end

    wr(ADDR, word(1'b1, 1'b0)); tick();
    check_sel("R4", 3'd1);
    wr(ADDR, word(1'b0, 1'b1));
    check_sel("R6", 3'd1);
    tick();
    check_sel("R6", 3'd0);
    tick();
    check_sel("R7", 3'd2);
    wr(ADDR, word(1'b1, 1'b0));
    tick();
    check_sel("R7", 3'd0);
    tick();
    check_sel("R7", 3'd1);
    clear_all();

    cfg_req = 1'b1; tick();
    check_sel("R4", 3'd4);
    wr(ADDR, word(1'b1, 1'b1));
    cfg_req = 1'b0;
    tick();
    check_sel("R6", 3'd0);
    tick();
    check_sel("R7", 3'd1);
    clear_all();

    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule